// File: doc/BRIEF.md
# Indexed Interrupt Source Configuration Block

This block is the device-side register file of an interrupt controller that sits behind a serial link. Software does not see one register per source. It writes a byte into an index register and then reads or writes a single 32-bit data window. The index decides which internal word the window shows. One fixed index returns the number of sources. Each source has a pair of words. The even index of the pair holds the mask, the trigger mode, the acknowledge-request flag and an 8-bit vector. The odd index of the pair is used to acknowledge the source.

Every source watches one input wire. A source set to edge mode latches each 0-to-1 transition of its input and sends it once. A source set to level mode sends while its input is high. If its acknowledge-request flag is set, it is then blocked until software acknowledges it. Software can acknowledge in two ways. It can write bit 31 of the source's odd word, or it can write a one into the source's bit of a separate bitmap register. Pending sources leave the block one at a time on a valid/ready stream that carries the vector and the source number.

Top module: `irqcap_regfile`

## Requirements
- R1: After reset every entry's even word reads 0x0000_0001 (masked, edge mode, no acknowledge request, vector 0), the index register reads 0, no source is waiting for an acknowledge and irq_valid is low.
- R2: A write to address 0x00 stores reg_wdata[7:0] as the index. A read of address 0x00 returns that byte in bits 7:0, with zeros in bits 31:8.
- R3: With index 0x01, the window at address 0x04 reads NSRC-1 in bits 23:16 and zero in all other bits. Writes through the window to that index have no effect.
- R4: With index 0x10+2*i, the window reads and writes source i's configuration word: bit 0 is the mask (1 = masked), bit 1 selects level mode, bit 5 requests an acknowledge and bits 23:16 hold the vector. All other bits read zero.
- R5: Indices other than 0x01 and 0x10 to 0x10+2*NSRC-1 read zero through the window. Writes to them change no entry.
- R6: In edge mode, a 0-to-1 transition on src_in latches a pending request even while the source is masked. The request is sent once after the source is unmasked, needs no acknowledge, and a held-high input does not send it again.
- R7: In level mode without an acknowledge request, an unmasked source with its input high sends again after each transfer for as long as the input stays high.
- R8: In level mode with an acknowledge request, a transfer blocks the source. While it is blocked, bit 31 of its odd word (index 0x11+2*i) reads 1 and the source sends nothing.
- R9: Writing the odd word with bit 31 = 1 acknowledges the source and clears the block. Writing it with bit 31 = 0 has no effect.
- R10: The bitmap acknowledge register for source s is at byte address 0x60 + ((s>>3)&~3), bit (s & 31). Writing 1 to that bit acknowledges s. Writing 0 has no effect.
- R11: irq_valid, irq_vector and irq_source stay stable until irq_ready is high. A transfer happens on a clock edge where both are high. When several sources are pending, the lowest-numbered one goes first.
- R12: If an acknowledge for a source lands in the same cycle as that source's transfer, the new block wins. If a new edge lands in the same cycle as an edge source's transfer, the new pending request is kept.
- R13: A masked level source sends nothing. Its high input is sent once the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address: 0x00 index, 0x04 window, 0x60+ acknowledge bitmap |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_in | input | NSRC | Interrupt input wire of each source |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | The consumer accepts the offered request |
| irq_vector | output | 8 | Vector of the offered request |
| irq_source | output | SRCW | Number of the offered source |

## Verification
Two events can meet in one clock edge. In the first, an acknowledge arrives for a source in the same cycle as that source's transfer. The bench provokes this by raising irq_ready and writing the bitmap acknowledge bit on the same edge. It then reads the odd word and expects bit 31 still set, with no new request offered. In the second, a fresh rising edge on an edge-mode input coincides with that source's transfer. The bench expects the same source to be offered again two edges later. Around these cases, the bench sweeps all 256 index values and every source in each trigger mode, and uses both acknowledge paths.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

  typedef struct packed {
    logic [7:0] vector;
    logic       req_eoi;
    logic       level;
    logic       mask;
  } entry_t;

  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h04;
  localparam logic [7:0] OFS_EOIMAP = 8'h60;

  localparam logic [7:0] IDX_COUNT  = 8'h01;
  localparam logic [7:0] IDX_ENTRY0 = 8'h10;

  localparam int BIT_MASK   = 0;
  localparam int BIT_LEVEL  = 1;
  localparam int BIT_REQEOI = 5;
  localparam int BIT_ACK    = 31;
  localparam int VEC_LSB    = 16;

  localparam entry_t ENTRY_RESET = '{vector: 8'h00, req_eoi: 1'b0, level: 1'b0, mask: 1'b1};

  function automatic logic [31:0] entry_to_word(entry_t e);
    logic [31:0] w;
    w = '0;
    w[BIT_MASK]             = e.mask;
    w[BIT_LEVEL]            = e.level;
    w[BIT_REQEOI]           = e.req_eoi;
    w[VEC_LSB +: 8]         = e.vector;
    return w;
  endfunction

  function automatic entry_t word_to_entry(logic [31:0] w);
    entry_t e;
    e.mask    = w[BIT_MASK];
    e.level   = w[BIT_LEVEL];
    e.req_eoi = w[BIT_REQEOI];
    e.vector  = w[VEC_LSB +: 8];
    return e;
  endfunction

endpackage

// File: rtl/irqcap_csr.sv
module irqcap_csr
  import irqcap_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int MAP_WORDS = (NSRC + 31) / 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NSRC-1:0]  wait_eoi,
  output entry_t           cfg [NSRC],
  output logic [NSRC-1:0]  eoi_clr
);

  logic [7:0] index_q;
  logic [7:0] rel;
  logic [6:0] ent_sel;
  logic       ent_hit;
  logic       ent_hi;
  logic       win_wr;
  logic [31:0] window_rd;
  entry_t     cfg_q [NSRC];
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign win_wr  = reg_wr && (reg_addr == OFS_WINDOW);
  assign rel     = index_q - IDX_ENTRY0;
  assign ent_hit = (index_q >= IDX_ENTRY0) && (int'(rel) < 2 * NSRC);
  assign ent_hi  = rel[0];
  assign ent_sel = rel[7:1];

  always_ff @(posedge clk) begin
    if (!rst_n) index_q <= '0;
    else if (reg_wr && reg_addr == OFS_INDEX) index_q <= reg_wdata[7:0];
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n) cfg_q[g] <= ENTRY_RESET;
        else if (win_wr && ent_hit && !ent_hi && int'(ent_sel) == g)
          cfg_q[g] <= word_to_entry(reg_wdata);
      end
      assign cfg[g] = cfg_q[g];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      eoi_clr[i] = (win_wr && ent_hit && ent_hi && int'(ent_sel) == i && reg_wdata[BIT_ACK])
                 || (reg_wr && reg_addr == (OFS_EOIMAP + 8'(4 * (i / 32))) && reg_wdata[i % 32]);
    end
  end

  always_comb begin
    window_rd = '0;
    if (index_q == IDX_COUNT) begin
      window_rd[VEC_LSB +: 8] = 8'(NSRC - 1);
    end else if (ent_hit) begin
      for (int i = 0; i < NSRC; i++) begin
        if (int'(ent_sel) == i) begin
          if (ent_hi) window_rd[BIT_ACK] = wait_eoi[i];
          else        window_rd = entry_to_word(cfg_q[i]);
        end
      end
    end
  end

  always_comb begin
    if (reg_addr == OFS_INDEX)       reg_rdata = {24'h0, index_q};
    else if (reg_addr == OFS_WINDOW) reg_rdata = window_rd;
    else                             reg_rdata = '0;
  end

  AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_INDEX) |=> (index_q == $past(reg_wdata[7:0]))); // R2

  initial begin
    if (MAP_WORDS > 8) $display("irqcap_csr: too many sources for the bitmap window");
  end

endmodule

// File: rtl/irqcap_src.sv
module irqcap_src
  import irqcap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in,
  input  entry_t cfg,
  input  logic   deliver,
  input  logic   eoi_clr,
  output logic   req,
  output logic   wait_eoi
);

  logic in_q;
  logic pend_q;
  logic wait_q;
  logic rise;

  assign rise = in && !in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      in_q   <= in;
      pend_q <= !cfg.level && (rise || (pend_q && !deliver));
      wait_q <= (deliver && cfg.level && cfg.req_eoi) || (wait_q && !eoi_clr);
    end
  end

  assign req      = !cfg.mask && (cfg.level ? (in && !wait_q) : pend_q);
  assign wait_eoi = wait_q;

  AST_WAIT_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && cfg.level && cfg.req_eoi) |=> wait_q); // R8

  AST_WAIT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_q) |-> $past(eoi_clr)); // R9, R10

  AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(in && !in_q)); // R6

endmodule

// File: rtl/irqcap_arb.sv
module irqcap_arb #(
  parameter int NSRC = 8,
  localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [7:0]      vec_tbl [NSRC],
  output logic            irq_valid,
  input  logic            irq_ready,
  output logic [7:0]      irq_vector,
  output logic [SRCW-1:0] irq_source,
  output logic [NSRC-1:0] deliver
);

  logic [NSRC-1:0] cand;
  logic [SRCW-1:0] pick_idx;
  logic [7:0]      pick_vec;
  logic            any;
  logic            xfer;

  assign xfer = irq_valid && irq_ready;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      cand[i]    = req[i] && !(irq_valid && irq_source == SRCW'(i));
      deliver[i] = xfer && irq_source == SRCW'(i);
    end
  end

  always_comb begin
    pick_idx = '0;
    pick_vec = '0;
    any      = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_idx = SRCW'(i);
        pick_vec = vec_tbl[i];
        any      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_source <= '0;
    end else if (!irq_valid || irq_ready) begin
      irq_valid <= any;
      if (any) begin
        irq_vector <= pick_vec;
        irq_source <= pick_idx;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vector) && $stable(irq_source))); // R11

  AST_OFFER_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(|req)); // R13

endmodule

// File: rtl/irqcap_regfile.sv
module irqcap_regfile
  import irqcap_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_valid,
  input  logic            irq_ready,
  output logic [7:0]      irq_vector,
  output logic [SRCW-1:0] irq_source
);

  entry_t          cfg [NSRC];
  logic [7:0]      vec_tbl [NSRC];
  logic [NSRC-1:0] eoi_clr;
  logic [NSRC-1:0] wait_eoi;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] deliver;

  irqcap_csr #(.NSRC(NSRC)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .wait_eoi (wait_eoi),
    .cfg      (cfg),
    .eoi_clr  (eoi_clr)
  );

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      irqcap_src u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .in      (src_in[g]),
        .cfg     (cfg[g]),
        .deliver (deliver[g]),
        .eoi_clr (eoi_clr[g]),
        .req     (req[g]),
        .wait_eoi(wait_eoi[g])
      );
      assign vec_tbl[g] = cfg[g].vector;
    end
  endgenerate

  irqcap_arb #(.NSRC(NSRC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .vec_tbl   (vec_tbl),
    .irq_valid (irq_valid),
    .irq_ready (irq_ready),
    .irq_vector(irq_vector),
    .irq_source(irq_source),
    .deliver   (deliver)
  );

endmodule

// File: tb/irqcap_regfile_test.sv
module irqcap_regfile_test;

  localparam int NSRC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_source;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irqcap_regfile #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
    .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_source(irq_source)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(r, reg_rdata, e);
  endtask

  task automatic cfg_src(input int i, input bit m, input bit lvl, input bit re, input logic [7:0] v);
    wr(8'h00, 32'(8'h10 + 2 * i));
    wr(8'h04, {8'h00, v, 10'h000, re, 3'b000, lvl, m});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic offer_chk(input string r, input int s, input logic [7:0] v);
    #1;
    chk(r, 32'(irq_valid), 32'd1);
    chk(r, 32'(irq_source), 32'(s));
    chk(r, 32'(irq_vector), 32'(v));
  endtask

  task automatic idle_chk(input string r);
    #1;
    chk(r, 32'(irq_valid), 32'd0);
  endtask

  task automatic take();
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    idle_chk("R1");
    rd(8'h00, 32'h0, "R1");
    for (int i = 0; i < NSRC; i++) begin
      wr(8'h00, 32'(8'h10 + 2 * i));
      rd(8'h04, 32'h1, "R1");
      wr(8'h00, 32'(8'h11 + 2 * i));
      rd(8'h04, 32'h0, "R1");
    end

    // R2, R3, R5: sweep of every index value
    for (int x = 0; x < 256; x++) begin
      logic [31:0] e;
      bit is_ent;
      is_ent = (x >= 16) && (x < 16 + 2 * NSRC);
      wr(8'h00, 32'hFFFF_FF00 | 32'(x));
      rd(8'h00, 32'(x), "R2");
      if (x == 1) e = 32'(NSRC - 1) << 16;
      else if (is_ent && (x % 2 == 0)) e = 32'h1;
      else e = 32'h0;
      rd(8'h04, e, is_ent ? "R1" : (x == 1 ? "R3" : "R5"));
      if (!is_ent && x != 1) wr(8'h04, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < NSRC; i++) begin
      wr(8'h00, 32'(8'h10 + 2 * i));
      rd(8'h04, 32'h1, "R5");
    end
    wr(8'h00, 32'h1);
    wr(8'h04, 32'h0);
    rd(8'h04, 32'(NSRC - 1) << 16, "R3");
    idle_chk("R5");

    // R4: configuration word round trip
    for (int i = 0; i < NSRC; i++) begin
      logic [31:0] w;
      w = {8'hFF, 8'(i * 37 + 5), 8'hA5, 8'(i * 13) | 8'h01};
      wr(8'h00, 32'(8'h10 + 2 * i));
      wr(8'h04, w);
      rd(8'h04, w & 32'h00FF_0023, "R4");
      wr(8'h04, 32'h1);
      rd(8'h04, 32'h1, "R4");
    end

    // R6: edge mode per source
    for (int i = 0; i < NSRC; i++) begin
      cfg_src(i, 1'b0, 1'b0, 1'b0, 8'(8'h80 + i));
      @(negedge clk); src_in[i] = 1'b1;
      cyc(3);
      offer_chk("R6", i, 8'(8'h80 + i));
      take();
      cyc(3);
      idle_chk("R6");
      src_in[i] = 1'b0;
      cfg_src(i, 1'b1, 1'b0, 1'b0, 8'h00);
    end

    // R8, R9, R10: level mode with acknowledge, both paths
    for (int i = 0; i < NSRC; i++) begin
      logic [7:0] hi_idx;
      hi_idx = 8'(8'h11 + 2 * i);
      cfg_src(i, 1'b0, 1'b1, 1'b1, 8'(8'hA0 + i));
      @(negedge clk); src_in[i] = 1'b1;
      cyc(3);
      offer_chk("R8", i, 8'(8'hA0 + i));
      take();
      cyc(3);
      idle_chk("R8");
      wr(8'h00, 32'(hi_idx));
      rd(8'h04, 32'h8000_0000, "R8");
      wr(8'h04, 32'h7FFF_FFFF);
      rd(8'h04, 32'h8000_0000, "R9");
      wr(8'h60, ~(32'h1 << i));
      rd(8'h04, 32'h8000_0000, "R10");
      if (i % 2 == 0) wr(8'h04, 32'h8000_0000);
      else            wr(8'h60, 32'h1 << i);
      rd(8'h04, 32'h0, (i % 2 == 0) ? "R9" : "R10");
      cyc(3);
      offer_chk((i % 2 == 0) ? "R9" : "R10", i, 8'(8'hA0 + i));
      take();
      src_in[i] = 1'b0;
      rd(8'h04, 32'h8000_0000, "R8");
      if (i % 2 == 0) wr(8'h04, 32'h8000_0000);
      else            wr(8'h60, 32'h1 << i);
      rd(8'h04, 32'h0, (i % 2 == 0) ? "R9" : "R10");
      cyc(3);
      idle_chk("R8");
      cfg_src(i, 1'b1, 1'b0, 1'b0, 8'h00);
    end

    // R7: level mode without acknowledge repeats while high
    cfg_src(1, 1'b0, 1'b1, 1'b0, 8'h55);
    @(negedge clk); src_in[1] = 1'b1;
    cyc(3);
    offer_chk("R7", 1, 8'h55);
    take();
    cyc(3);
    offer_chk("R7", 1, 8'h55);
    take();
    src_in[1] = 1'b0;
    cyc(3);
    idle_chk("R7");
    cfg_src(1, 1'b1, 1'b0, 1'b0, 8'h00);

    // R11: lowest source first, offer held stable
    cfg_src(2, 1'b0, 1'b0, 1'b0, 8'h22);
    cfg_src(5, 1'b0, 1'b0, 1'b0, 8'h5A);
    @(negedge clk); src_in[2] = 1'b1; src_in[5] = 1'b1;
    cyc(3);
    offer_chk("R11", 2, 8'h22);
    cyc(4);
    offer_chk("R11", 2, 8'h22);
    take();
    cyc(1);
    offer_chk("R11", 5, 8'h5A);
    take();
    cyc(2);
    idle_chk("R11");
    src_in[2] = 1'b0; src_in[5] = 1'b0;
    cfg_src(2, 1'b1, 1'b0, 1'b0, 8'h00);
    cfg_src(5, 1'b1, 1'b0, 1'b0, 8'h00);

    // R13: masked level source
    cfg_src(3, 1'b1, 1'b1, 1'b0, 8'h33);
    @(negedge clk); src_in[3] = 1'b1;
    cyc(4);
    idle_chk("R13");
    cfg_src(3, 1'b0, 1'b1, 1'b0, 8'h33);
    cyc(2);
    offer_chk("R13", 3, 8'h33);
    take();
    src_in[3] = 1'b0;
    cyc(3);
    idle_chk("R13");
    cfg_src(3, 1'b1, 1'b0, 1'b0, 8'h00);

    // R6: edge latched while masked
    cfg_src(7, 1'b1, 1'b0, 1'b0, 8'h77);
    @(negedge clk); src_in[7] = 1'b1;
    @(negedge clk); src_in[7] = 1'b0;
    cyc(2);
    idle_chk("R6");
    cfg_src(7, 1'b0, 1'b0, 1'b0, 8'h77);
    cyc(2);
    offer_chk("R6", 7, 8'h77);
    take();
    cyc(3);
    idle_chk("R6");
    cfg_src(7, 1'b1, 1'b0, 1'b0, 8'h00);

    // R12: acknowledge in the same cycle as the transfer
    cfg_src(4, 1'b0, 1'b1, 1'b1, 8'h44);
    @(negedge clk); src_in[4] = 1'b1;
    cyc(3);
    offer_chk("R12", 4, 8'h44);
    @(negedge clk);
    irq_ready = 1'b1; reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h1 << 4;
    @(negedge clk);
    irq_ready = 1'b0; reg_wr = 1'b0;
    wr(8'h00, 32'h19);
    rd(8'h04, 32'h8000_0000, "R12");
    cyc(2);
    idle_chk("R12");
    src_in[4] = 1'b0;
    wr(8'h60, 32'h1 << 4);
    rd(8'h04, 32'h0, "R12");
    cfg_src(4, 1'b1, 1'b0, 1'b0, 8'h00);

    // R12: new edge in the same cycle as the transfer
    cfg_src(6, 1'b0, 1'b0, 1'b0, 8'h66);
    @(negedge clk); src_in[6] = 1'b1;
    cyc(3);
    offer_chk("R12", 6, 8'h66);
    src_in[6] = 1'b0;
    @(negedge clk); irq_ready = 1'b1; src_in[6] = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
    cyc(2);
    offer_chk("R12", 6, 8'h66);
    take();
    src_in[6] = 1'b0;
    cyc(3);
    idle_chk("R12");

    finish_run();
  end

endmodule